// File: doc/BRIEF.md
# LCD Controller Instruction Decoder

This block accepts one parallel instruction word each time its strobe is high, decodes it and holds the control state that drives a dot-matrix LCD. Four kinds of state are kept. The first is a blanking flag that forces every drive output to the low supply. The second is a power mode, which is either running or power-saving; in power-saving mode the oscillator is stopped. The third is a pair of one-cycle shift-enable pulses with a direction bit. The fourth is an address counter made of a character RAM pointer and an attribute RAM pointer. Every instruction word comes from a serial receiver that sits in front of the block. The outputs feed the RAMs, the oscillator and the waveform generator.

The power mode is a two-state machine. `ST_RUN` means normal operation with the oscillator on. `ST_SLEEP` means power saving. The transition `GO_SLEEP` (from `ST_RUN` to `ST_SLEEP`) fires on a display-control word with the sleep bit set. The transition `WAKE` (from `ST_SLEEP` to `ST_RUN`) fires on a display-control word with the sleep bit clear. In `ST_SLEEP` only display-control words are acted on.

Word layout (16 bits). The opcode is in bits [15:12]: 1 = display control, 2 = shift, 3 = load address counter. All other opcodes are unrecognised.
- Display control: bit 1 = blank, bit 0 = sleep.
- Shift: bit 2 = main select, bit 1 = attribute select, bit 0 = direction (0 right, 1 left).
- Load address counter: bits [5:0] = character address, bits [9:6] = attribute address, with the LSB of each field in its lowest bit.

Top module: `lcd_instr_decoder`

## Requirements
- R1: After reset, `osc_en_o`=1 (state `ST_RUN`), `drive_off_o`=1 (blank set), both addresses are 0, and both shift pulses and `shift_left_o` are 0.
- R2: In `ST_RUN`, a display-control word (opcode 1) loads its bit 1 into the blank flag. From the next cycle on, `drive_off_o` equals that bit.
- R3: A display-control word with bit 0 = 1 takes the FSM to `ST_SLEEP` (transition `GO_SLEEP`). While in `ST_SLEEP`, `osc_en_o`=0 and `drive_off_o`=1, whatever the blank flag holds.
- R4: In `ST_SLEEP`, a display-control word with bit 0 = 0 takes the FSM back to `ST_RUN` (transition `WAKE`). It also loads the blank flag from bit 1.
- R5: A shift word (opcode 2) with main select bit 2 and attribute select bit 1 pulses `shift_main_o` when bit 2 = 1 and `shift_attr_o` when bit 1 = 1. When both bits are 0, neither pulses.
- R6: Each shift pulse is high for exactly the one cycle that follows the accepted strobe.
- R7: A shift word loads its bit 0 into `shift_left_o` (0 = right, 1 = left).
- R8: A load-address word (opcode 3) loads bits [5:0] into `char_addr_o` and bits [9:6] into `attr_addr_o` in the same cycle. The addresses change on no other event.
- R9: In `ST_SLEEP`, shift and load-address words have no effect: there are no pulses, and the addresses and direction stay unchanged.
- R10: A word with an unrecognised opcode, or any word presented with the strobe low, leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Instruction word |
| strobe_i | input | 1 | Instruction valid, one cycle |
| drive_off_o | output | 1 | Force all drive outputs to low supply |
| osc_en_o | output | 1 | Oscillator enable |
| shift_main_o | output | 1 | Main data shift pulse |
| shift_attr_o | output | 1 | Attribute data shift pulse |
| shift_left_o | output | 1 | Shift direction, 1 = left |
| char_addr_o | output | 6 | Character RAM address counter |
| attr_addr_o | output | 4 | Attribute RAM address counter |

## Verification
The assertions assume that the strobe only ever qualifies a fully formed word and that reset is held through at least one clock edge. The bench drives each word and its strobe together on the falling edge. It lowers the strobe one cycle later, so every word is seen exactly once. Shift and load-address words are sent deliberately while in `ST_SLEEP`, and a fully populated word is presented with the strobe low. This exercises the conditions under which the block must ignore its input.

// File: rtl/lcdi_pkg.sv
package lcdi_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_DISPLAY = 4'h1;
    localparam logic [OPC_W-1:0] OPC_SHIFT   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_LOAD_AC = 4'h3;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic is_disp;
        logic is_shift;
        logic is_load;
        logic blank;
        logic sleep;
        logic sel_main;
        logic sel_attr;
        logic left;
    } dec_t;
endpackage

// File: rtl/lcdi_decode.sv
module lcdi_decode
    import lcdi_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int CHAR_AW = 6,
    parameter int ATTR_AW = 4
) (
    input  logic [WORD_W-1:0]  word_i,
    output dec_t               dec_o,
    output logic [CHAR_AW-1:0] char_a_o,
    output logic [ATTR_AW-1:0] attr_a_o
);
    localparam int OPC_LSB  = WORD_W - OPC_W;
    localparam int ATTR_LSB = CHAR_AW;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc            = word_i[OPC_LSB +: OPC_W];
        dec_o          = '0;
        dec_o.is_disp  = (opc == OPC_DISPLAY);
        dec_o.is_shift = (opc == OPC_SHIFT);
        dec_o.is_load  = (opc == OPC_LOAD_AC);
        dec_o.blank    = word_i[1];
        dec_o.sleep    = word_i[0];
        dec_o.sel_main = word_i[2];
        dec_o.sel_attr = word_i[1];
        dec_o.left     = word_i[0];
        char_a_o       = word_i[0 +: CHAR_AW];
        attr_a_o       = word_i[ATTR_LSB +: ATTR_AW];
    end
endmodule

// File: rtl/lcdi_power_fsm.sv
module lcdi_power_fsm
    import lcdi_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic disp_we_i,
    input  logic blank_i,
    input  logic sleep_i,
    output logic asleep_o,
    output logic osc_en_o,
    output logic drive_off_o
);
    pwr_state_e state_q, state_d;
    logic       blank_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (disp_we_i && sleep_i)  state_d = ST_SLEEP; // GO_SLEEP
            ST_SLEEP: if (disp_we_i && !sleep_i) state_d = ST_RUN;   // WAKE
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_RUN;
            blank_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (disp_we_i) blank_q <= blank_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                asleep_o    = 1'b0;
                osc_en_o    = 1'b1;
                drive_off_o = blank_q;
            end
            ST_SLEEP: begin
                asleep_o    = 1'b1;
                osc_en_o    = 1'b0;
                drive_off_o = 1'b1;
            end
            default: begin
                asleep_o    = 1'b0;
                osc_en_o    = 1'b1;
                drive_off_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lcdi_shift_ctrl.sv
module lcdi_shift_ctrl #(
    parameter int N_CHAN = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fire_i,
    input  logic [N_CHAN-1:0] sel_i,
    input  logic              left_i,
    output logic [N_CHAN-1:0] pulse_o,
    output logic              left_o
);
    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        always_ff @(posedge clk_i) begin
            if (rst_i) pulse_o[g] <= 1'b0;
            else       pulse_o[g] <= fire_i && sel_i[g];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       left_o <= 1'b0;
        else if (fire_i) left_o <= left_i;
    end
endmodule

// File: rtl/lcdi_addr_counter.sv
module lcdi_addr_counter #(
    parameter int CHAR_AW = 6,
    parameter int ATTR_AW = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [CHAR_AW-1:0] char_a_i,
    input  logic [ATTR_AW-1:0] attr_a_i,
    output logic [CHAR_AW-1:0] char_a_o,
    output logic [ATTR_AW-1:0] attr_a_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            char_a_o <= '0;
            attr_a_o <= '0;
        end else if (load_i) begin
            char_a_o <= char_a_i;
            attr_a_o <= attr_a_i;
        end
    end
endmodule

// File: rtl/lcd_instr_decoder.sv
module lcd_instr_decoder
    import lcdi_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int CHAR_AW = 6,
    parameter int ATTR_AW = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [WORD_W-1:0]  instr_i,
    input  logic               strobe_i,
    output logic               drive_off_o,
    output logic               osc_en_o,
    output logic               shift_main_o,
    output logic               shift_attr_o,
    output logic               shift_left_o,
    output logic [CHAR_AW-1:0] char_addr_o,
    output logic [ATTR_AW-1:0] attr_addr_o
);
    localparam int N_CHAN = 2;

    dec_t               dec;
    logic [CHAR_AW-1:0] char_a;
    logic [ATTR_AW-1:0] attr_a;
    logic               asleep;
    logic               disp_we, shift_fire, ac_load;
    logic [N_CHAN-1:0]  pulses;

    lcdi_decode #(.WORD_W(WORD_W), .CHAR_AW(CHAR_AW), .ATTR_AW(ATTR_AW)) u_decode (
        .word_i  (instr_i),
        .dec_o   (dec),
        .char_a_o(char_a),
        .attr_a_o(attr_a)
    );

    assign disp_we    = strobe_i && dec.is_disp;
    assign shift_fire = strobe_i && dec.is_shift && !asleep;
    assign ac_load    = strobe_i && dec.is_load  && !asleep;

    lcdi_power_fsm u_power (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .disp_we_i  (disp_we),
        .blank_i    (dec.blank),
        .sleep_i    (dec.sleep),
        .asleep_o   (asleep),
        .osc_en_o   (osc_en_o),
        .drive_off_o(drive_off_o)
    );

    lcdi_shift_ctrl #(.N_CHAN(N_CHAN)) u_shift (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .fire_i (shift_fire),
        .sel_i  ({dec.sel_attr, dec.sel_main}),
        .left_i (dec.left),
        .pulse_o(pulses),
        .left_o (shift_left_o)
    );

    assign shift_main_o = pulses[0];
    assign shift_attr_o = pulses[1];

    lcdi_addr_counter #(.CHAR_AW(CHAR_AW), .ATTR_AW(ATTR_AW)) u_ac (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (ac_load),
        .char_a_i(char_a),
        .attr_a_i(attr_a),
        .char_a_o(char_addr_o),
        .attr_a_o(attr_addr_o)
    );
endmodule

// File: rtl/lcd_instr_decoder_chk.sv
module lcd_instr_decoder_chk #(
    parameter int CHAR_AW = 6,
    parameter int ATTR_AW = 4
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               strobe_i,
    input logic               drive_off_o,
    input logic               osc_en_o,
    input logic               shift_main_o,
    input logic               shift_attr_o,
    input logic               shift_left_o,
    input logic [CHAR_AW-1:0] char_addr_o,
    input logic [ATTR_AW-1:0] attr_addr_o
);
    AST_SLEEP_DRIVE_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !osc_en_o |-> drive_off_o); // R3

    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_main_o || shift_attr_o) |-> $past(strobe_i)); // R6

    AST_PULSE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_main_o || shift_attr_o) |-> $past(osc_en_o)); // R9

    AST_ADDR_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(strobe_i) |-> ($stable(char_addr_o) && $stable(attr_addr_o))); // R8

    AST_SLEEP_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(osc_en_o) |-> ($stable(char_addr_o) && $stable(attr_addr_o) && $stable(shift_left_o))); // R9
endmodule

bind lcd_instr_decoder lcd_instr_decoder_chk #(.CHAR_AW(CHAR_AW), .ATTR_AW(ATTR_AW)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .strobe_i    (strobe_i),
    .drive_off_o (drive_off_o),
    .osc_en_o    (osc_en_o),
    .shift_main_o(shift_main_o),
    .shift_attr_o(shift_attr_o),
    .shift_left_o(shift_left_o),
    .char_addr_o (char_addr_o),
    .attr_addr_o (attr_addr_o)
);

// File: tb/lcd_instr_decoder_tb.sv
module lcd_instr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic        strobe = 1'b0;
    logic        drive_off, osc_en, sh_main, sh_attr, sh_left;
    logic [5:0]  char_a;
    logic [3:0]  attr_a;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_instr_decoder u_dut (
        .clk_i(clk), .rst_i(rst), .instr_i(instr), .strobe_i(strobe),
        .drive_off_o(drive_off), .osc_en_o(osc_en),
        .shift_main_o(sh_main), .shift_attr_o(sh_attr), .shift_left_o(sh_left),
        .char_addr_o(char_a), .attr_addr_o(attr_a)
    );

    function automatic logic [15:0] w_disp(input logic blank, input logic sleep);
        return {4'h1, 10'b0, blank, sleep};
    endfunction
    function automatic logic [15:0] w_shift(input logic m, input logic a, input logic left);
        return {4'h2, 9'b0, m, a, left};
    endfunction
    function automatic logic [15:0] w_load(input logic [5:0] c, input logic [3:0] t);
        return {4'h3, 2'b0, t, c};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the word is taken
    task automatic send(input logic [15:0] w);
        instr = w; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; instr = '0;
    endtask

    task automatic t_reset();
        chk("R1 osc_en", osc_en, 1);
        chk("R1 drive_off", drive_off, 1);
        chk("R1 char_addr", char_a, 0);
        chk("R1 attr_addr", attr_a, 0);
        chk("R1 pulses", {sh_main, sh_attr, sh_left}, 0);
    endtask

    task automatic t_blank();
        send(w_disp(1'b0, 1'b0));
        chk("R2 unblank", drive_off, 0);
        send(w_disp(1'b1, 1'b0));
        chk("R2 blank", drive_off, 1);
        send(w_disp(1'b0, 1'b0));
        chk("R2 unblank again", drive_off, 0);
    endtask

    task automatic t_shift();
        for (int k = 0; k < 8; k++) begin
            logic m, a, l;
            {m, a, l} = k[2:0];
            send(w_shift(m, a, l));
            chk("R5 main pulse", sh_main, m);
            chk("R5 attr pulse", sh_attr, a);
            chk("R7 direction", sh_left, l);
            @(negedge clk);
            chk("R6 pulse ends", {sh_main, sh_attr}, 0);
            chk("R7 direction held", sh_left, l);
        end
    endtask

    task automatic t_load();
        send(w_load(6'h2A, 4'h9));
        chk("R8 char", char_a, 'h2A);
        chk("R8 attr", attr_a, 'h9);
        send(w_load(6'h3F, 4'hF));
        chk("R8 char max", char_a, 'h3F);
        chk("R8 attr max", attr_a, 'hF);
        send(w_load(6'h05, 4'h2));
        chk("R8 char lsb", char_a, 'h05);
        chk("R8 attr lsb", attr_a, 'h2);
    endtask

    task automatic t_sleep();
        send(w_disp(1'b0, 1'b1));
        chk("R3 osc off", osc_en, 0);
        chk("R3 drive off despite blank=0", drive_off, 1);
        send(w_shift(1'b1, 1'b1, 1'b0));
        chk("R9 no pulse in sleep", {sh_main, sh_attr}, 0);
        chk("R9 dir held in sleep", sh_left, 1);
        send(w_load(6'h11, 4'h3));
        chk("R9 char held in sleep", char_a, 'h05);
        chk("R9 attr held in sleep", attr_a, 'h2);
        send(w_disp(1'b1, 1'b1));
        chk("R3 still asleep", osc_en, 0);
        send(w_disp(1'b0, 1'b0));
        chk("R4 wake osc", osc_en, 1);
        chk("R4 wake blank from word", drive_off, 0);
        send(w_load(6'h11, 4'h3));
        chk("R4 load works after wake", char_a, 'h11);
    endtask

    task automatic t_ignore();
        send({4'h7, 2'b0, 4'hF, 6'h3F});
        chk("R10 unknown opcode addr", {attr_a, char_a}, {4'h3, 6'h11});
        chk("R10 unknown opcode drive", drive_off, 0);
        chk("R10 unknown opcode osc", osc_en, 1);
        instr = w_disp(1'b1, 1'b1); strobe = 1'b0;
        @(negedge clk);
        chk("R10 no strobe osc", osc_en, 1);
        chk("R10 no strobe drive", drive_off, 0);
        instr = w_load(6'h00, 4'h0);
        @(negedge clk);
        chk("R10 no strobe addr", char_a, 'h11);
        instr = w_shift(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10 no strobe pulse", {sh_main, sh_attr}, 0);
        instr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_blank();
        t_shift();
        t_load();
        t_sleep();
        t_ignore();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule